// File: doc/BRIEF.md
# Guarded Shared Channel Arbiter

This block is a shared message channel that several client processes reach through their own request ports. Each client places one call at a time. A call is an opcode and, for a put, one data word. The channel serves exactly one call per arbitration slot. A put runs only while the internal queue has room, and a get runs only while the queue holds an item. The two query calls report whether the queue is empty or full, and they can always run.

Among the clients that are requesting and whose guard is true, a rotating pointer picks the one to serve. A client whose guard is false keeps its request up and waits. The arbiter passes over it without stalling the other clients. Results return on that client's own data and status outputs in the same cycle as its acknowledge pulse.

Top module: `guarded_channel`

## Requirements
- R1: A synchronous active-high reset empties the queue, clears every acknowledge and status output, and sets the rotating pointer to client 0.
- R2: A client holds `req_i` high with a stable opcode until it receives a single-cycle `ack_o` pulse. The pulse comes in the cycle after the grant, and at most one client is acknowledged in any cycle. Opcodes on 2 bits: 0 = put, 1 = get, 2 = query empty, 3 = query full.
- R3: Items leave the queue in the order they were put, across all clients. Get data on `rdata_o` is valid in the ack cycle.
- R4: A put is not granted while the queue holds DEPTH items. It stays pending until a get frees a slot, and then it completes.
- R5: A get is not granted while the queue is empty. It stays pending until a put supplies an item, and then it returns that item.
- R6: Query calls are always granted. `stat_o` is 1 when the queried condition held at the grant, and 0 otherwise. Put and get calls return status 0.
- R7: After client k is granted, the next grant goes to the first eligible client found by searching upward from k+1, wrapping after the last client.
- R8: A pending client whose guard is false is skipped, so other eligible clients are still served.
- R9: An acknowledge goes only to a client that was requesting in the previous cycle.
- R10: The queue holds exactly DEPTH items. Its occupancy never exceeds DEPTH and changes only in a cycle that carries a put or get acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N_CLIENTS | Per-client call request |
| op_i | input | 2*N_CLIENTS | Per-client opcode, client i at bits [2i+1:2i] |
| wdata_i | input | DATA_W*N_CLIENTS | Per-client put data |
| ack_o | output | N_CLIENTS | Per-client one-cycle call completion |
| rdata_o | output | DATA_W*N_CLIENTS | Per-client get result, valid with ack |
| stat_o | output | N_CLIENTS | Per-client query result, valid with ack |

## Verification
The assertions check, on every cycle, the following:
- acknowledges are one-hot and last a single cycle;
- an acknowledge goes only to a requester;
- a put never completes against a full queue, and a get never completes against an empty one;
- occupancy stays within DEPTH and moves only with an acknowledged put or get.

Some behaviours can be shown only by the bench's scenarios:
- the FIFO order of the data;
- the exact rotation order of grants;
- the values returned by queries;
- the release of a blocked caller once the other side acts.

// File: rtl/gc_pkg.sv
package gc_pkg;
  typedef enum logic [1:0] {
    OP_PUT   = 2'd0,
    OP_GET   = 2'd1,
    OP_EMPTY = 2'd2,
    OP_FULL  = 2'd3
  } gc_op_e;
endpackage

// File: rtl/gc_queue.sv
module gc_queue #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] head,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  assign head  = mem[rd_ptr];
  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
endmodule

// File: rtl/gc_guard.sv
module gc_guard
  import gc_pkg::*;
#(
  parameter int N_CLIENTS = 4
) (
  input  logic [N_CLIENTS-1:0]   req,
  input  logic [2*N_CLIENTS-1:0] op,
  input  logic [N_CLIENTS-1:0]   busy,
  input  logic                   full,
  input  logic                   empty,
  output logic [N_CLIENTS-1:0]   elig
);
  for (genvar i = 0; i < N_CLIENTS; i++) begin : g_cl
    gc_op_e o;
    logic   guard_ok;
    assign o = gc_op_e'(op[2*i +: 2]);
    always_comb begin
      case (o)
        OP_PUT:  guard_ok = !full;
        OP_GET:  guard_ok = !empty;
        default: guard_ok = 1'b1;
      endcase
    end
    assign elig[i] = req[i] && !busy[i] && guard_ok;
  end
endmodule

// File: rtl/gc_rr_pick.sv
module gc_rr_pick #(
  parameter int N_CLIENTS = 4,
  localparam int IDX_W = (N_CLIENTS > 1) ? $clog2(N_CLIENTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_CLIENTS-1:0] elig,
  output logic                 gnt_valid,
  output logic [IDX_W-1:0]     gnt_idx
);
  logic [IDX_W-1:0] ptr;
  int idx;

  always_comb begin
    gnt_valid = 1'b0;
    gnt_idx   = '0;
    idx       = 0;
    for (int k = 0; k < N_CLIENTS; k++) begin
      idx = int'(ptr) + k;
      if (idx >= N_CLIENTS) idx = idx - N_CLIENTS;
      if (!gnt_valid && elig[idx]) begin
        gnt_valid = 1'b1;
        gnt_idx   = IDX_W'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (gnt_valid)
      ptr <= (gnt_idx == IDX_W'(N_CLIENTS - 1)) ? '0 : gnt_idx + 1'b1;
  end
endmodule

// File: rtl/guarded_channel.sv
module guarded_channel
  import gc_pkg::*;
#(
  parameter int N_CLIENTS = 4,
  parameter int DATA_W    = 8,
  parameter int DEPTH     = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [N_CLIENTS-1:0]          req_i,
  input  logic [2*N_CLIENTS-1:0]        op_i,
  input  logic [DATA_W*N_CLIENTS-1:0]   wdata_i,
  output logic [N_CLIENTS-1:0]          ack_o,
  output logic [DATA_W*N_CLIENTS-1:0]   rdata_o,
  output logic [N_CLIENTS-1:0]          stat_o
);
  localparam int IDX_W = (N_CLIENTS > 1) ? $clog2(N_CLIENTS) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [N_CLIENTS-1:0] elig;
  logic                 gnt_valid;
  logic [IDX_W-1:0]     gnt_idx;
  gc_op_e               g_op;
  logic                 push, pop, q_full, q_empty;
  logic [DATA_W-1:0]    q_head, g_wdata;
  logic [CNT_W-1:0]     q_count;

  gc_guard #(.N_CLIENTS(N_CLIENTS)) u_guard (
    .req(req_i), .op(op_i), .busy(ack_o),
    .full(q_full), .empty(q_empty), .elig(elig)
  );

  gc_rr_pick #(.N_CLIENTS(N_CLIENTS)) u_pick (
    .clk(clk), .rst(rst), .elig(elig),
    .gnt_valid(gnt_valid), .gnt_idx(gnt_idx)
  );

  assign g_op    = gc_op_e'(op_i[2*gnt_idx +: 2]);
  assign g_wdata = wdata_i[DATA_W*gnt_idx +: DATA_W];
  assign push    = gnt_valid && (g_op == OP_PUT);
  assign pop     = gnt_valid && (g_op == OP_GET);

  gc_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .din(g_wdata),
    .head(q_head), .count(q_count), .full(q_full), .empty(q_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_o   <= '0;
      stat_o  <= '0;
      rdata_o <= '0;
    end else begin
      ack_o <= '0;
      if (gnt_valid) begin
        ack_o[gnt_idx] <= 1'b1;
        case (g_op)
          OP_EMPTY: stat_o[gnt_idx] <= q_empty;
          OP_FULL:  stat_o[gnt_idx] <= q_full;
          default:  stat_o[gnt_idx] <= 1'b0;
        endcase
        if (pop) rdata_o[DATA_W*gnt_idx +: DATA_W] <= q_head;
      end
    end
  end
endmodule

// File: rtl/gc_checker.sv
module gc_checker #(
  parameter int N_CLIENTS = 4,
  parameter int DEPTH     = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic                   clk,
  input logic                   rst,
  input logic [N_CLIENTS-1:0]   req,
  input logic [2*N_CLIENTS-1:0] op,
  input logic [N_CLIENTS-1:0]   ack,
  input logic [CNT_W-1:0]       count
);
  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(ack)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) count <= CNT_W'(DEPTH)); // R10
  AST_COUNT_QUIET: assert property (@(posedge clk) disable iff (rst) (ack == '0) |-> $stable(count)); // R10

  for (genvar i = 0; i < N_CLIENTS; i++) begin : g_cl
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst) ack[i] |=> !ack[i]); // R2
    AST_ACK_REQ: assert property (@(posedge clk) disable iff (rst) ack[i] |-> $past(req[i])); // R9
    AST_GET_GUARD: assert property (@(posedge clk) disable iff (rst)
      (ack[i] && $past(op[2*i +: 2]) == 2'd1) |-> $past(count) != '0); // R5
    AST_PUT_GUARD: assert property (@(posedge clk) disable iff (rst)
      (ack[i] && $past(op[2*i +: 2]) == 2'd0) |-> $past(count) < CNT_W'(DEPTH)); // R4
  end
endmodule

bind guarded_channel gc_checker #(.N_CLIENTS(N_CLIENTS), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .req(req_i), .op(op_i), .ack(ack_o), .count(q_count)
);

// File: tb/test_guarded_channel.sv
module test_guarded_channel;
  localparam int N = 4;
  localparam int DW = 8;
  localparam int NV = 13;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N-1:0]    req_r = '0;
  logic [2*N-1:0]  op_r = '0;
  logic [DW*N-1:0] wd_r = '0;
  logic [N-1:0]    ack;
  logic [DW*N-1:0] rdata;
  logic [N-1:0]    stat;

  always #2.5 clk = ~clk;

  guarded_channel #(.N_CLIENTS(N), .DATA_W(DW), .DEPTH(4)) i_guarded_channel (
    .clk(clk), .rst(rst), .req_i(req_r), .op_i(op_r), .wdata_i(wd_r),
    .ack_o(ack), .rdata_o(rdata), .stat_o(stat)
  );

  int n_chk = 0, n_fail = 0;
  int order [16];
  int n_ord;
  logic [DW-1:0] cap_d [N];
  logic          cap_s [N];

  // {client[1:0], op[1:0], wdata[7:0], exp_data[7:0], exp_stat}
  localparam logic [20:0] VEC [NV] = '{
    {2'd0, 2'd2, 8'h00, 8'h00, 1'b1},
    {2'd1, 2'd3, 8'h00, 8'h00, 1'b0},
    {2'd0, 2'd0, 8'h11, 8'h00, 1'b0},
    {2'd2, 2'd0, 8'h22, 8'h00, 1'b0},
    {2'd1, 2'd0, 8'h33, 8'h00, 1'b0},
    {2'd3, 2'd0, 8'h44, 8'h00, 1'b0},
    {2'd2, 2'd3, 8'h00, 8'h00, 1'b1},
    {2'd3, 2'd2, 8'h00, 8'h00, 1'b0},
    {2'd1, 2'd1, 8'h00, 8'h11, 1'b0},
    {2'd0, 2'd1, 8'h00, 8'h22, 1'b0},
    {2'd3, 2'd1, 8'h00, 8'h33, 1'b0},
    {2'd2, 2'd1, 8'h00, 8'h44, 1'b0},
    {2'd0, 2'd2, 8'h00, 8'h00, 1'b1}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic start(input int cl, input logic [1:0] op, input logic [7:0] wd);
    req_r[cl] = 1'b1;
    op_r[2*cl +: 2] = op;
    wd_r[DW*cl +: DW] = wd;
  endtask

  // Watchdog: a call group that does not drain in time counts as a failure.
  task automatic run_idle();
    int t;
    n_ord = 0;
    t = 0;
    while (req_r != '0 && t < 60) begin
      @(negedge clk);
      t++;
      for (int i = 0; i < N; i++) begin
        if (ack[i]) begin
          if (n_ord < 16) order[n_ord] = i;
          n_ord++;
          cap_d[i] = rdata[DW*i +: DW];
          cap_s[i] = stat[i];
          req_r[i] = 1'b0;
        end
      end
    end
    if (req_r != '0) check(1'b0, "watchdog", int'(req_r), 0);
  endtask

  task automatic call(input int cl, input logic [1:0] op, input logic [7:0] wd);
    start(cl, op, wd);
    run_idle();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic hold_quiet(input int cycles, input string tag);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      check(ack == '0, tag, int'(ack), 0);
    end
  endtask

  initial begin
    // R1: reset state
    do_reset();
    check(ack == '0 && stat == '0, "R1 reset outputs", int'({ack, stat}), 0);
    call(2, 2'd2, 8'h0);
    check(cap_s[2] == 1'b1, "R1 empty after reset", int'(cap_s[2]), 1);

    // Table walk: R2 R3 R6 (single calls, FIFO order across clients)
    do_reset();
    for (int v = 0; v < NV; v++) begin
      logic [20:0] e;
      int cl;
      e = VEC[v];
      cl = int'(e[20:19]);
      call(cl, e[18:17], e[16:9]);
      check(n_ord == 1 && order[0] == cl, "R2 single ack", order[0], cl);
      check(cap_s[cl] == e[0], "R6 status", int'(cap_s[cl]), int'(e[0]));
      if (e[18:17] == 2'd1)
        check(cap_d[cl] == e[8:1], "R3 get data order", int'(cap_d[cl]), int'(e[8:1]));
    end

    // R7: round-robin order
    do_reset();
    @(negedge clk);
    start(1, 2'd2, 0); start(2, 2'd2, 0); start(3, 2'd3, 0);
    run_idle();
    check(n_ord == 3 && order[0] == 1 && order[1] == 2 && order[2] == 3,
          "R7 rotation 1,2,3", order[0]*100 + order[1]*10 + order[2], 123);
    @(negedge clk);
    start(0, 2'd2, 0); start(2, 2'd2, 0);
    run_idle();
    check(order[0] == 0 && order[1] == 2, "R7 wrap to 0", order[0]*10 + order[1], 2);
    @(negedge clk);
    start(0, 2'd3, 0); start(1, 2'd3, 0); start(3, 2'd3, 0);
    run_idle();
    check(order[0] == 3 && order[1] == 0 && order[2] == 1,
          "R7 resume after 2", order[0]*100 + order[1]*10 + order[2], 301);

    // R5 / R8: get blocked on empty, put by another client proceeds
    do_reset();
    @(negedge clk);
    start(0, 2'd1, 0);
    hold_quiet(5, "R5 get waits while empty");
    start(1, 2'd0, 8'h5A);
    run_idle();
    check(order[0] == 1 && order[1] == 0, "R8 blocked client skipped", order[0]*10 + order[1], 10);
    check(cap_d[0] == 8'h5A, "R5 released get data", int'(cap_d[0]), 'h5A);

    // R4 / R10: fill to depth, put blocks, get frees a slot
    do_reset();
    for (int k = 0; k < 4; k++) call(0, 2'd0, 8'hA0 + 8'(k));
    call(1, 2'd3, 0);
    check(cap_s[1] == 1'b1, "R10 full at DEPTH items", int'(cap_s[1]), 1);
    @(negedge clk);
    start(2, 2'd0, 8'h77);
    hold_quiet(4, "R4 put waits while full");
    start(3, 2'd1, 0);
    run_idle();
    check(order[0] == 3 && order[1] == 2, "R4 get first then put", order[0]*10 + order[1], 32);
    check(cap_d[3] == 8'hA0, "R3 oldest item", int'(cap_d[3]), 'hA0);
    for (int k = 1; k < 4; k++) begin
      call(1, 2'd1, 0);
      check(cap_d[1] == 8'hA0 + 8'(k), "R3 wrap order", int'(cap_d[1]), 'hA0 + k);
    end
    call(1, 2'd1, 0);
    check(cap_d[1] == 8'h77, "R4 late put stored", int'(cap_d[1]), 'h77);
    call(0, 2'd2, 0);
    check(cap_s[0] == 1'b1, "R6 empty again", int'(cap_s[0]), 1);

    // R9: no request, no ack
    hold_quiet(3, "R9 idle no ack");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule